// File: doc/BRIEF.md
# User-Level Interrupt CSR Bank

This block holds the user-mode trap control registers of a core that lets user code take its own interrupts. It sits beside the machine-level register file and answers a single CSR port. The port carries a 12-bit address, a write enable and write data. The block returns read data in the same cycle and raises a flag when the access is not allowed.

Five of the eight registers are real storage: scratch, cause, trap value, return PC and trap vector. The other three are filtered windows onto machine state:

- **Status** shows only the user-visible fields of the machine status word.
- **Interrupt enable** shows the machine enable register after two stages of delegation masking.
- **Interrupt pending** shows the machine pending register after the same two stages of delegation masking.

A write to one of these three windows does not store anything here. Instead, the block merges the new bits into the current machine value and presents the merged word on a write-back port with a one-cycle strobe. The machine register file captures that word at the next clock edge.

Top module: `utrap_csr_bank`

## Requirements
- R1: The eight legal addresses are:

  | Address | Register |
  |---------|----------|
  | 0x000 | status |
  | 0x004 | interrupt enable |
  | 0x005 | trap vector |
  | 0x040 | scratch |
  | 0x041 | return PC |
  | 0x042 | cause |
  | 0x043 | trap value |
  | 0x044 | interrupt pending |

  Any other address with `csrValid` high sets `csrIllegal`.
- R2: When user mode or the user-interrupt extension is disabled, every access is illegal. An illegal access changes no stored register, raises no write-back strobe and reads as zero.
- R3: A status read returns the machine status word masked to bit 0 (interrupt enable) and bit 4 (previous interrupt enable). A legal status write strobes `statusWrStrobe`. Its data equals the machine status with only bits 0 and 4 replaced from the write data.
- R4: An enable read returns `machIe & machDeleg & supDeleg`, further limited to the user interrupt bits: software at bit 0, timer at bit 4, external at bit 8.
- R5: A legal enable write strobes `ieWrStrobe`. Its data replaces only those user interrupt bits that both delegation masks pass; all other bits keep the old `machIe` value.
- R6: A pending read applies the R4 filter to `machIp`. A legal pending write can change only the software bit (bit 0), and only when that bit is delegated by both masks. All other bits keep the old `machIp` value.
- R7: The trap vector reads as {base, 0, mode}. A write always stores the base with bits 1:0 cleared. A written mode of 0 (direct) or 1 (vectored) is stored. A written mode of 2 or 3 leaves the previous mode in place.
- R8: The return PC reads as the stored value with bit 0 cleared when `compressedEn` is 1, and with bits 1:0 cleared when it is 0. The write itself stores all bits.
- R9: Scratch, cause and trap value store every written bit. A later read returns exactly the written value.
- R10: A read in the same cycle as a write to that address returns the value from before the write. The new value is readable from the next cycle on.
- R11: After reset, all stored registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| userModeEn | input | 1 | User mode implemented |
| userIrqEn | input | 1 | User-interrupt extension enabled |
| compressedEn | input | 1 | Compressed instructions supported (2-byte PC alignment) |
| csrValid | input | 1 | Access request this cycle |
| csrWrEn | input | 1 | Access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data (pre-write value) |
| csrIllegal | output | 1 | Access not permitted |
| machStatus | input | XLEN | Machine status word |
| machIe | input | XLEN | Machine interrupt enable |
| machIp | input | XLEN | Machine interrupt pending |
| machDeleg | input | XLEN | Machine-level interrupt delegation mask |
| supDeleg | input | XLEN | Supervisor-level interrupt delegation mask |
| statusWrStrobe | output | 1 | Write machine status this cycle |
| statusWrData | output | XLEN | Merged machine status |
| ieWrStrobe | output | 1 | Write machine enable this cycle |
| ieWrData | output | XLEN | Merged machine enable |
| ipWrStrobe | output | 1 | Write machine pending this cycle |
| ipWrData | output | XLEN | Merged machine pending |

## Verification
These outputs are combinational, so they are due in the cycle an access is driven:

- read data
- the illegal flag
- the write-back strobes and their merged data

The bench drives inputs on the falling edge and samples them one nanosecond later. That is before the rising edge that commits any write. Values held in storage are due one cycle after the write. The bench checks them with a separate read on the following falling edge, so that one rising edge lies between the write and the read. The same sampling point lets the bench check R10, because the read taken in the write cycle still shows the old value.

// File: rtl/utrap_pkg.sv
package utrap_pkg;
  localparam logic [11:0] ADDR_STATUS  = 12'h000;
  localparam logic [11:0] ADDR_IE      = 12'h004;
  localparam logic [11:0] ADDR_VEC     = 12'h005;
  localparam logic [11:0] ADDR_SCRATCH = 12'h040;
  localparam logic [11:0] ADDR_EPC     = 12'h041;
  localparam logic [11:0] ADDR_CAUSE   = 12'h042;
  localparam logic [11:0] ADDR_TVAL    = 12'h043;
  localparam logic [11:0] ADDR_IP      = 12'h044;

  localparam int NUM_SEL   = 8;
  localparam int SEL_STAT  = 0;
  localparam int SEL_IE    = 1;
  localparam int SEL_IP    = 2;
  localparam int SEL_VEC   = 3;
  localparam int SEL_EPC   = 4;
  localparam int SEL_PLAIN = 5;  // scratch, cause, tval follow in order
  localparam int NUM_PLAIN = 3;

  localparam int IRQ_SW  = 0;
  localparam int IRQ_TMR = 4;
  localparam int IRQ_EXT = 8;
  localparam int ST_IE   = 0;
  localparam int ST_PIE  = 4;

  typedef struct packed {
    logic               wr;    // legal write this cycle
    logic [NUM_SEL-1:0] sel;   // one-hot register select, zero if illegal
  } csrCtl_t;
endpackage

// File: rtl/utrap_ctrl.sv
module utrap_ctrl
  import utrap_pkg::*;
(
  input  logic        userModeEn,
  input  logic        userIrqEn,
  input  logic        csrValid,
  input  logic        csrWrEn,
  input  logic [11:0] csrAddr,
  output csrCtl_t     ctl,
  output logic        csrIllegal
);
  logic [NUM_SEL-1:0] decSel;
  logic               featureOn;
  logic               legal;

  always_comb begin
    decSel = '0;
    unique case (csrAddr)
      ADDR_STATUS:  decSel[SEL_STAT]      = 1'b1;
      ADDR_IE:      decSel[SEL_IE]        = 1'b1;
      ADDR_IP:      decSel[SEL_IP]        = 1'b1;
      ADDR_VEC:     decSel[SEL_VEC]       = 1'b1;
      ADDR_EPC:     decSel[SEL_EPC]       = 1'b1;
      ADDR_SCRATCH: decSel[SEL_PLAIN]     = 1'b1;
      ADDR_CAUSE:   decSel[SEL_PLAIN + 1] = 1'b1;
      ADDR_TVAL:    decSel[SEL_PLAIN + 2] = 1'b1;
      default:      decSel                = '0;
    endcase
  end

  assign featureOn  = userModeEn & userIrqEn;
  assign legal      = csrValid & featureOn & (|decSel);
  assign csrIllegal = csrValid & ~legal;
  assign ctl.sel    = legal ? decSel : '0;
  assign ctl.wr     = legal & csrWrEn;
endmodule

// File: rtl/utrap_dp.sv
module utrap_dp
  import utrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            compressedEn,
  input  csrCtl_t         ctl,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  input  logic [XLEN-1:0] machStatus,
  input  logic [XLEN-1:0] machIe,
  input  logic [XLEN-1:0] machIp,
  input  logic [XLEN-1:0] machDeleg,
  input  logic [XLEN-1:0] supDeleg,
  output logic            statusWrStrobe,
  output logic [XLEN-1:0] statusWrData,
  output logic            ieWrStrobe,
  output logic [XLEN-1:0] ieWrData,
  output logic            ipWrStrobe,
  output logic [XLEN-1:0] ipWrData
);
  localparam logic [XLEN-1:0] IRQ_MASK =
    (XLEN'(1) << IRQ_SW) | (XLEN'(1) << IRQ_TMR) | (XLEN'(1) << IRQ_EXT);
  localparam logic [XLEN-1:0] STAT_MASK =
    (XLEN'(1) << ST_IE) | (XLEN'(1) << ST_PIE);
  localparam logic [XLEN-1:0] SWP_MASK = XLEN'(1) << IRQ_SW;

  logic [XLEN-1:0] delegMask, ipWrMask, alignMask;
  logic [XLEN-1:0] userStatus, userIe, userIp;
  logic [XLEN-3:0] vecBase;
  logic            vecMode;
  logic [XLEN-1:0] epcQ;
  logic [XLEN-1:0] plainQ [NUM_PLAIN];

  assign delegMask = machDeleg & supDeleg & IRQ_MASK;
  assign ipWrMask  = delegMask & SWP_MASK;
  assign alignMask = compressedEn ? ~XLEN'(1) : ~XLEN'(3);

  assign userStatus = machStatus & STAT_MASK;
  assign userIe     = machIe & delegMask;
  assign userIp     = machIp & delegMask;

  // Merge-back onto machine registers
  assign statusWrData   = (machStatus & ~STAT_MASK) | (csrWdata & STAT_MASK);
  assign ieWrData       = (machIe & ~delegMask) | (csrWdata & delegMask);
  assign ipWrData       = (machIp & ~ipWrMask) | (csrWdata & ipWrMask);
  assign statusWrStrobe = ctl.wr & ctl.sel[SEL_STAT];
  assign ieWrStrobe     = ctl.wr & ctl.sel[SEL_IE];
  assign ipWrStrobe     = ctl.wr & ctl.sel[SEL_IP];

  // Trap vector: 4-byte aligned base, reserved modes keep the old mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecBase <= '0;
      vecMode <= 1'b0;
    end else if (ctl.wr && ctl.sel[SEL_VEC]) begin
      vecBase <= csrWdata[XLEN-1:2];
      if (!csrWdata[1]) vecMode <= csrWdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) epcQ <= '0;
    else if (ctl.wr && ctl.sel[SEL_EPC]) epcQ <= csrWdata;
  end

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rstN) plainQ[i] <= '0;
      else if (ctl.wr && ctl.sel[SEL_PLAIN + i]) plainQ[i] <= csrWdata;
    end
  end

  always_comb begin
    csrRdata = '0;
    if (ctl.sel[SEL_STAT]) csrRdata = userStatus;
    if (ctl.sel[SEL_IE])   csrRdata = userIe;
    if (ctl.sel[SEL_IP])   csrRdata = userIp;
    if (ctl.sel[SEL_VEC])  csrRdata = {vecBase, 1'b0, vecMode};
    if (ctl.sel[SEL_EPC])  csrRdata = epcQ & alignMask;
    for (int k = 0; k < NUM_PLAIN; k++)
      if (ctl.sel[SEL_PLAIN + k]) csrRdata = plainQ[k];
  end
endmodule

// File: rtl/utrap_csr_bank.sv
module utrap_csr_bank
  import utrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            userModeEn,
  input  logic            userIrqEn,
  input  logic            compressedEn,
  input  logic            csrValid,
  input  logic            csrWrEn,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  output logic            csrIllegal,
  input  logic [XLEN-1:0] machStatus,
  input  logic [XLEN-1:0] machIe,
  input  logic [XLEN-1:0] machIp,
  input  logic [XLEN-1:0] machDeleg,
  input  logic [XLEN-1:0] supDeleg,
  output logic            statusWrStrobe,
  output logic [XLEN-1:0] statusWrData,
  output logic            ieWrStrobe,
  output logic [XLEN-1:0] ieWrData,
  output logic            ipWrStrobe,
  output logic [XLEN-1:0] ipWrData
);
  csrCtl_t ctl;

  utrap_ctrl u_ctrl (
    .userModeEn(userModeEn), .userIrqEn(userIrqEn), .csrValid(csrValid),
    .csrWrEn(csrWrEn), .csrAddr(csrAddr), .ctl(ctl), .csrIllegal(csrIllegal)
  );

  utrap_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .compressedEn(compressedEn), .ctl(ctl),
    .csrWdata(csrWdata), .csrRdata(csrRdata),
    .machStatus(machStatus), .machIe(machIe), .machIp(machIp),
    .machDeleg(machDeleg), .supDeleg(supDeleg),
    .statusWrStrobe(statusWrStrobe), .statusWrData(statusWrData),
    .ieWrStrobe(ieWrStrobe), .ieWrData(ieWrData),
    .ipWrStrobe(ipWrStrobe), .ipWrData(ipWrData)
  );
endmodule

// File: rtl/utrap_csr_bank_chk.sv
module utrap_csr_bank_chk
  import utrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            userModeEn,
  input logic            userIrqEn,
  input logic            compressedEn,
  input logic            csrValid,
  input logic            csrWrEn,
  input logic [11:0]     csrAddr,
  input logic [XLEN-1:0] csrWdata,
  input logic [XLEN-1:0] csrRdata,
  input logic            csrIllegal,
  input logic [XLEN-1:0] machStatus,
  input logic [XLEN-1:0] machIe,
  input logic [XLEN-1:0] machIp,
  input logic [XLEN-1:0] machDeleg,
  input logic [XLEN-1:0] supDeleg,
  input logic            statusWrStrobe,
  input logic [XLEN-1:0] statusWrData,
  input logic            ieWrStrobe,
  input logic [XLEN-1:0] ieWrData,
  input logic            ipWrStrobe,
  input logic [XLEN-1:0] ipWrData
);
  localparam logic [XLEN-1:0] USR_ST = XLEN'(32'h11);

  a_r2_disabled_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !(userModeEn && userIrqEn)) |-> csrIllegal);

  a_r2_no_strobe_illegal: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> !(statusWrStrobe || ieWrStrobe || ipWrStrobe));

  a_r3_status_user_only: assert property (@(posedge clk) disable iff (!rstN)
    statusWrStrobe |-> (((statusWrData ^ machStatus) & ~USR_ST) == '0));

  a_r5_ie_keeps_nondeleg: assert property (@(posedge clk) disable iff (!rstN)
    ieWrStrobe |-> (((ieWrData ^ machIe) & ~(machDeleg & supDeleg)) == '0));

  a_r6_ip_only_sw: assert property (@(posedge clk) disable iff (!rstN)
    ipWrStrobe |-> (((ipWrData ^ machIp) & ~XLEN'(1)) == '0));

  a_r8_epc_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !csrIllegal && csrAddr == ADDR_EPC) |->
      (csrRdata[0] == 1'b0 && (compressedEn || csrRdata[1] == 1'b0)));

  a_r9_scratch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrWrEn && !csrIllegal && csrAddr == ADDR_SCRATCH) |=>
      ((csrValid && !csrIllegal && csrAddr == ADDR_SCRATCH) ->
        csrRdata == $past(csrWdata)));
endmodule

bind utrap_csr_bank utrap_csr_bank_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_utrap_csr_bank.sv
module sim_utrap_csr_bank;
  localparam int XLEN = 32;
  logic clk = 1'b0, rstN = 1'b0;
  logic userModeEn = 1'b1, userIrqEn = 1'b1, compressedEn = 1'b1;
  logic csrValid = 1'b0, csrWrEn = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [XLEN-1:0] csrWdata = '0, csrRdata;
  logic csrIllegal;
  logic [XLEN-1:0] machStatus = '0, machIe = '0, machIp = '0;
  logic [XLEN-1:0] machDeleg = '0, supDeleg = '0;
  logic statusWrStrobe, ieWrStrobe, ipWrStrobe;
  logic [XLEN-1:0] statusWrData, ieWrData, ipWrData;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  utrap_csr_bank #(.XLEN(XLEN)) u0 (.*);

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic [11:0] a, logic w, logic [XLEN-1:0] d);
    @(negedge clk);
    csrValid = 1'b1; csrWrEn = w; csrAddr = a; csrWdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    csrValid = 1'b0; csrWrEn = 1'b0;
  endtask

  task automatic t_reset();
    acc(12'h040, 0, 0); chk("R11 scratch", csrRdata, 0);
    acc(12'h005, 0, 0); chk("R11 vec", csrRdata, 0);
    acc(12'h041, 0, 0); chk("R11 epc", csrRdata, 0);
  endtask

  task automatic t_plain();
    acc(12'h040, 1, 32'hDEADBEEF); chk("R10 pre-write", csrRdata, 0);
    acc(12'h040, 0, 0);            chk("R9 scratch", csrRdata, 32'hDEADBEEF);
    acc(12'h042, 1, 32'h80000004);
    acc(12'h043, 1, 32'h12345678);
    acc(12'h042, 0, 0);            chk("R9 cause", csrRdata, 32'h80000004);
    acc(12'h043, 0, 0);            chk("R9 tval", csrRdata, 32'h12345678);
  endtask

  task automatic t_vec();
    acc(12'h005, 1, 32'h10000001); acc(12'h005, 0, 0);
    chk("R7 vectored", csrRdata, 32'h10000001);
    acc(12'h005, 1, 32'h20000003); acc(12'h005, 0, 0);
    chk("R7 reserved keeps 1", csrRdata, 32'h20000001);
    acc(12'h005, 1, 32'h30000000); acc(12'h005, 0, 0);
    chk("R7 direct", csrRdata, 32'h30000000);
    acc(12'h005, 1, 32'h40000006); acc(12'h005, 0, 0);
    chk("R7 reserved keeps 0", csrRdata, 32'h40000004);
  endtask

  task automatic t_epc();
    acc(12'h041, 1, 32'h00001003);
    compressedEn = 1'b1; acc(12'h041, 0, 0);
    chk("R8 compressed", csrRdata, 32'h00001002);
    compressedEn = 1'b0; acc(12'h041, 0, 0);
    chk("R8 no compressed", csrRdata, 32'h00001000);
    compressedEn = 1'b1;
  endtask

  task automatic t_status();
    machStatus = 32'hFFFFFFFF; acc(12'h000, 0, 0);
    chk("R3 read", csrRdata, 32'h11);
    machStatus = 32'hAAAAAAAA; acc(12'h000, 1, 32'h00000010);
    chk("R3 strobe", {31'b0, statusWrStrobe}, 1);
    chk("R3 merge", statusWrData, 32'hAAAAAABA);
  endtask

  task automatic t_ie();
    machIe = 32'hFFF; machDeleg = 32'h011; supDeleg = 32'h111;
    acc(12'h004, 0, 0); chk("R4 read", csrRdata, 32'h011);
    acc(12'h004, 1, 0);
    chk("R5 strobe", {31'b0, ieWrStrobe}, 1);
    chk("R5 clear deleg", ieWrData, 32'hFEE);
    machIe = 0; acc(12'h004, 1, 32'hFFFFFFFF);
    chk("R5 set deleg", ieWrData, 32'h011);
  endtask

  task automatic t_ip();
    machIp = 32'h111; machDeleg = 32'h111; supDeleg = 32'h111;
    acc(12'h044, 0, 0); chk("R6 read", csrRdata, 32'h111);
    acc(12'h044, 1, 0); chk("R6 sw only", ipWrData, 32'h110);
    machIp = 0; machDeleg = 0; acc(12'h044, 1, 32'h1);
    chk("R6 not delegated", ipWrData, 32'h0);
  endtask

  task automatic t_illegal();
    acc(12'h001, 0, 0); chk("R1 bad addr", {31'b0, csrIllegal}, 1);
    acc(12'h043, 0, 0); chk("R1 good addr", {31'b0, csrIllegal}, 0);
    userIrqEn = 1'b0;
    acc(12'h040, 1, 32'h55);
    chk("R2 illegal flag", {31'b0, csrIllegal}, 1);
    chk("R2 reads zero", csrRdata, 0);
    acc(12'h000, 1, 32'h11);
    chk("R2 no strobe", {31'b0, statusWrStrobe}, 0);
    userIrqEn = 1'b1; userModeEn = 1'b0;
    acc(12'h044, 0, 0); chk("R2 no user mode", {31'b0, csrIllegal}, 1);
    userModeEn = 1'b1;
    acc(12'h040, 0, 0); chk("R2 write ignored", csrRdata, 32'hDEADBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset(); t_plain(); t_vec(); t_epc();
    t_status(); t_ie(); t_ip(); t_illegal();
    idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule